// File: doc/BRIEF.md
# Busbar Differential Trip Decision Logic

This block decides when a low-impedance busbar differential scheme trips. It works on sampled values from an upstream stage: an operating quantity and a smoothed restraint quantity for every phase of three zones. The zones are bus A, bus B and an overall check zone. On each sample strobe, every zone-phase element tests whether the operating quantity clears a fixed pickup and also a settable fraction of the restraint. It then looks for unbroken runs of such samples that last one qualifying interval.

A run of that length is a "count". With no external fault flagged, the first count gives a fast trip. Two counts close together give a secure trip. A separate detector looks for through-fault conditions, meaning high restraint while the operating quantity stays small. When it sees them, it raises an external fault flag, and the flag blocks the fast path for a fixed hold time. Trip outputs stay latched until a clear input is pulsed.

A breaker gate combines the per-zone trips with the selector positions and the breaker closed status of each feeder. It produces the trip command for each breaker.

Top module: `bus_diff_trip`

## Requirements
- R1: On a strobe, an element's operate condition is true only when its operating value is strictly greater than `pickup` and the operating value times 256 is strictly greater than `slope_k` times the restraint value (`slope_k` is unsigned with 8 fractional bits).
- R2: A count is produced on the 8th consecutive strobe with the operate condition true. A strobe with the condition false restarts the run. After a count, the next count needs 8 further consecutive true strobes.
- R3: A count while the element's external fault flag is clear sets that element's fast trip.
- R4: A count that follows the previous count of the same element by at most 16 strobes sets the secure trip. A spacing of more than 16 strobes does not.
- R5: The external fault flag sets after 8 consecutive strobes in which the operating value is below `pickup` and the restraint value is above `pickup`. It stays set for exactly 288 strobes after the qualifying strobe, and a new qualification reloads it.
- R6: While the external fault flag is set, counts never set the fast trip, but they still set the secure trip.
- R7: A feeder's breaker trip is `((zone A tripped AND sel_a) OR (zone B tripped AND sel_b)) AND check zone tripped AND brk_closed`. A zone is tripped when any of its phase elements holds a fast or secure trip. Element index is zone*3+phase, with zone A=0, B=1, check=2.
- R8: Fast and secure trips stay latched until `trip_clr` is high at a clock edge, which clears them. The clear overrides a new trip in the same cycle.
- R9: After reset, all trip, flag and breaker outputs are low.
- R10: Clock cycles without `smp_stb` leave the trips and flags unchanged, except for the clear of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| trip_clr | input | 1 | Clears latched trips |
| pickup | input | W | Minimum operate threshold |
| slope_k | input | KW | Slope setting, 8 fractional bits |
| op_flat | input | NEL*W | Operating values, element e at bits [e*W +: W] |
| res_flat | input | NEL*W | Smoothed restraint values, same layout |
| sel_a | input | NFEED | Feeder on bus A selector closed |
| sel_b | input | NFEED | Feeder on bus B selector closed |
| brk_closed | input | NFEED | Feeder breaker closed |
| fast_trip | output | NEL | Latched fast trip per element |
| secure_trip | output | NEL | Latched secure trip per element |
| ext_flag | output | NEL | External fault flag per element |
| brk_trip | output | NFEED | Breaker trip command per feeder |

## Verification
The stimulus covers several input patterns, and each one separates a pair of cases:
- Values that pass only the pickup, or only the slope, separate the two halves of the operate test.
- A run broken one sample short shows whether the run really restarts.
- A through-fault pattern followed by operate runs shows whether the fast path is blocked while the secure path still works.
- Counts spaced 18 samples apart, and then 8 apart, separate the two sides of the pairing window.
- The flag is watched across strobe 287 and strobe 288 to pin down the hold length.
- Patterns of selectors and breaker status, with single zones tripped, confirm that the check zone and breaker terms gate the zone trip.

// File: rtl/bus_diff_pkg.sv
package bus_diff_pkg;
    localparam int ZONES    = 3;
    localparam int ZONE_A   = 0;
    localparam int ZONE_B   = 1;
    localparam int ZONE_CHK = 2;
    localparam int KFRAC    = 8;
endpackage

// File: rtl/bus_diff_operate.sv
module bus_diff_operate #(
    parameter int W    = 16,
    parameter int KW   = 10,
    parameter int QUAL = 8,
    parameter int WIN  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic          clr,
    input  logic [W-1:0]  op,
    input  logic [W-1:0]  res,
    input  logic [W-1:0]  pickup,
    input  logic [KW-1:0] slope_k,
    input  logic          blk,
    output logic          fast_o,
    output logic          secure_o
);
    import bus_diff_pkg::*;

    localparam int RW = $clog2(QUAL + 1);
    localparam int GW = $clog2(WIN + 1);
    localparam int PW = W + KW;

    typedef struct packed {
        logic [RW-1:0] run;
        logic [GW-1:0] gap;
        logic          seen;
        logic          fast;
        logic          secure;
    } op_state_t;

    op_state_t st_d, st_q;
    logic [PW-1:0] lhs, rhs;
    logic          cond;
    logic          evt;

    always_comb begin
        lhs  = PW'(op) << KFRAC;
        rhs  = PW'(slope_k) * PW'(res);
        cond = (op > pickup) && (lhs > rhs);
        st_d = st_q;
        evt  = 1'b0;
        if (stb) begin
            if (cond) begin
                if (st_q.run == RW'(QUAL - 1)) begin
                    st_d.run = '0;
                    evt      = 1'b1;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
            if (evt) begin
                if (!blk) st_d.fast = 1'b1;
                if (st_q.seen && (st_q.gap < GW'(WIN))) st_d.secure = 1'b1;
                st_d.gap  = '0;
                st_d.seen = 1'b1;
            end else if (st_q.gap != GW'(WIN)) begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
        if (clr) begin
            st_d.fast   = 1'b0;
            st_d.secure = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fast_o   = st_q.fast;
    assign secure_o = st_q.secure;
endmodule

// File: rtl/bus_diff_extfault.sv
module bus_diff_extfault #(
    parameter int W    = 16,
    parameter int QUAL = 8,
    parameter int HOLD = 288
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] op,
    input  logic [W-1:0] res,
    input  logic [W-1:0] pickup,
    output logic         ext_o
);
    localparam int RW = $clog2(QUAL + 1);
    localparam int TW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic [TW-1:0] tmr;
    } ef_state_t;

    ef_state_t st_d, st_q;
    logic      quiet;
    logic      load;

    always_comb begin
        quiet = (op < pickup) && (res > pickup);
        st_d  = st_q;
        load  = 1'b0;
        if (stb) begin
            if (quiet) begin
                if (st_q.run == RW'(QUAL - 1)) begin
                    st_d.run = '0;
                    load     = 1'b1;
                end else begin
                    st_d.run = st_q.run + 1'b1;
                end
            end else begin
                st_d.run = '0;
            end
            if (load)                 st_d.tmr = TW'(HOLD);
            else if (st_q.tmr != '0)  st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_o = (st_q.tmr != '0);
endmodule

// File: rtl/bus_diff_brkgate.sv
module bus_diff_brkgate #(
    parameter int NFEED = 6
) (
    input  logic [2:0]       zone_trip,
    input  logic [NFEED-1:0] sel_a,
    input  logic [NFEED-1:0] sel_b,
    input  logic [NFEED-1:0] closed,
    output logic [NFEED-1:0] brk
);
    import bus_diff_pkg::*;

    for (genvar f = 0; f < NFEED; f++) begin : g_feed
        always_comb begin
            brk[f] = ((zone_trip[ZONE_A] & sel_a[f]) | (zone_trip[ZONE_B] & sel_b[f]))
                   & zone_trip[ZONE_CHK] & closed[f];
        end
    end
endmodule

// File: rtl/bus_diff_trip.sv
module bus_diff_trip #(
    parameter int W     = 16,
    parameter int KW    = 10,
    parameter int NPH   = 3,
    parameter int NFEED = 6,
    parameter int QUAL  = 8,
    parameter int WIN   = 16,
    parameter int HOLD  = 288,
    parameter int NEL   = 3 * NPH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_stb,
    input  logic               trip_clr,
    input  logic [W-1:0]       pickup,
    input  logic [KW-1:0]      slope_k,
    input  logic [NEL*W-1:0]   op_flat,
    input  logic [NEL*W-1:0]   res_flat,
    input  logic [NFEED-1:0]   sel_a,
    input  logic [NFEED-1:0]   sel_b,
    input  logic [NFEED-1:0]   brk_closed,
    output logic [NEL-1:0]     fast_trip,
    output logic [NEL-1:0]     secure_trip,
    output logic [NEL-1:0]     ext_flag,
    output logic [NFEED-1:0]   brk_trip
);
    import bus_diff_pkg::*;

    logic [ZONES-1:0] zone_trip;

    for (genvar e = 0; e < NEL; e++) begin : g_el
        bus_diff_extfault #(.W(W), .QUAL(QUAL), .HOLD(HOLD)) u_ef (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (smp_stb),
            .op     (op_flat[e*W +: W]),
            .res    (res_flat[e*W +: W]),
            .pickup (pickup),
            .ext_o  (ext_flag[e])
        );
        bus_diff_operate #(.W(W), .KW(KW), .QUAL(QUAL), .WIN(WIN)) u_op (
            .clk      (clk),
            .rst_n    (rst_n),
            .stb      (smp_stb),
            .clr      (trip_clr),
            .op       (op_flat[e*W +: W]),
            .res      (res_flat[e*W +: W]),
            .pickup   (pickup),
            .slope_k  (slope_k),
            .blk      (ext_flag[e]),
            .fast_o   (fast_trip[e]),
            .secure_o (secure_trip[e])
        );
    end

    for (genvar z = 0; z < ZONES; z++) begin : g_zone
        assign zone_trip[z] = |(fast_trip[z*NPH +: NPH] | secure_trip[z*NPH +: NPH]);
    end

    bus_diff_brkgate #(.NFEED(NFEED)) u_gate (
        .zone_trip (zone_trip),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .closed    (brk_closed),
        .brk       (brk_trip)
    );
endmodule

// File: rtl/bus_diff_trip_checks.sv
module bus_diff_trip_checks #(
    parameter int W     = 16,
    parameter int KW    = 10,
    parameter int NPH   = 3,
    parameter int NFEED = 6,
    parameter int QUAL  = 8,
    parameter int WIN   = 16,
    parameter int HOLD  = 288,
    parameter int NEL   = 3 * NPH
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_stb,
    input logic               trip_clr,
    input logic [W-1:0]       pickup,
    input logic [KW-1:0]      slope_k,
    input logic [NEL*W-1:0]   op_flat,
    input logic [NEL*W-1:0]   res_flat,
    input logic [NFEED-1:0]   sel_a,
    input logic [NFEED-1:0]   sel_b,
    input logic [NFEED-1:0]   brk_closed,
    input logic [NEL-1:0]     fast_trip,
    input logic [NEL-1:0]     secure_trip,
    input logic [NEL-1:0]     ext_flag,
    input logic [NFEED-1:0]   brk_trip
);
    for (genvar e = 0; e < NEL; e++) begin : g_el
        assert_fast_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fast_trip[e] && !trip_clr) |=> fast_trip[e]);
        assert_secure_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (secure_trip[e] && !trip_clr) |=> secure_trip[e]);
        assert_no_fast_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fast_trip[e]) |-> !$past(ext_flag[e]));
        assert_flag_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ext_flag[e]) |-> $past(smp_stb));
    end

    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && !trip_clr) |=> ($stable(fast_trip) && $stable(secure_trip) && $stable(ext_flag)));

    for (genvar f = 0; f < NFEED; f++) begin : g_fd
        assert_brk_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
            brk_trip[f] |-> (brk_closed[f] && (sel_a[f] || sel_b[f])));
    end
endmodule

bind bus_diff_trip bus_diff_trip_checks #(
    .W(W), .KW(KW), .NPH(NPH), .NFEED(NFEED), .QUAL(QUAL), .WIN(WIN), .HOLD(HOLD), .NEL(NEL)
) u_chk (.*);

// File: tb/bus_diff_trip_test.sv
module bus_diff_trip_test;
    localparam int W = 16, KW = 10, NPH = 3, NFEED = 6, NEL = 9;

    logic clk = 0;
    logic rst_n = 0;
    logic smp_stb = 0, trip_clr = 0;
    logic [W-1:0] pickup = 16'd100;
    logic [KW-1:0] slope_k = 10'd128;
    logic [W-1:0] op_v [NEL];
    logic [W-1:0] res_v [NEL];
    logic [NEL*W-1:0] op_flat, res_flat;
    logic [NFEED-1:0] sel_a = '0, sel_b = '0, brk_closed = '0;
    logic [NEL-1:0] fast_trip, secure_trip, ext_flag;
    logic [NFEED-1:0] brk_trip;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int e = 0; e < NEL; e++) begin
            op_flat[e*W +: W]  = op_v[e];
            res_flat[e*W +: W] = res_v[e];
        end
    end

    bus_diff_trip uut (.*);

    // behavioural reference
    int m_run[NEL], m_q[NEL], m_gap[NEL], m_tmr[NEL];
    bit m_seen[NEL], m_fast[NEL], m_sec[NEL];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NEL; e++) begin
                m_run[e] = 0; m_q[e] = 0; m_gap[e] = 0; m_tmr[e] = 0;
                m_seen[e] = 0; m_fast[e] = 0; m_sec[e] = 0;
            end
        end else begin
            for (int e = 0; e < NEL; e++) begin
                if (smp_stb) begin
                    bit c, ev, q, ld;
                    longint o, r;
                    o = op_v[e]; r = res_v[e];
                    c = (o > pickup) && (o * 256 > longint'(slope_k) * r);
                    ev = 0;
                    if (c) begin
                        m_run[e]++;
                        if (m_run[e] == 8) begin m_run[e] = 0; ev = 1; end
                    end else m_run[e] = 0;
                    if (ev) begin
                        if (m_tmr[e] == 0) m_fast[e] = 1;
                        if (m_seen[e] && m_gap[e] + 1 <= 16) m_sec[e] = 1;
                        m_gap[e] = 0; m_seen[e] = 1;
                    end else if (m_gap[e] < 16) m_gap[e]++;
                    q = (o < pickup) && (r > pickup);
                    ld = 0;
                    if (q) begin
                        m_q[e]++;
                        if (m_q[e] == 8) begin m_q[e] = 0; ld = 1; end
                    end else m_q[e] = 0;
                    if (ld) m_tmr[e] = 288;
                    else if (m_tmr[e] > 0) m_tmr[e]--;
                end
                if (trip_clr) begin m_fast[e] = 0; m_sec[e] = 0; end
            end
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit za, zb, zc;
            logic [NFEED-1:0] eb;
            za = 0; zb = 0; zc = 0;
            for (int e = 0; e < NEL; e++) begin
                chk(fast_trip[e] == m_fast[e], "R3 R6 fast per-cycle", fast_trip[e], m_fast[e]);
                chk(secure_trip[e] == m_sec[e], "R4 secure per-cycle", secure_trip[e], m_sec[e]);
                chk(ext_flag[e] == (m_tmr[e] != 0), "R5 flag per-cycle", ext_flag[e], m_tmr[e] != 0);
                if (m_fast[e] || m_sec[e]) begin
                    if (e < 3) za = 1; else if (e < 6) zb = 1; else zc = 1;
                end
            end
            for (int f = 0; f < NFEED; f++)
                eb[f] = ((za & sel_a[f]) | (zb & sel_b[f])) & zc & brk_closed[f];
            chk(brk_trip == eb, "R7 breaker per-cycle", brk_trip, eb);
        end
    end

    task automatic sample(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 smp_stb = 1;
            @(posedge clk); #1 smp_stb = 0;
            repeat (2) @(posedge clk);
            #1;
        end
    endtask

    task automatic set_all(int o, int r);
        for (int e = 0; e < NEL; e++) begin op_v[e] = W'(o); res_v[e] = W'(r); end
    endtask

    task automatic clear_trips();
        trip_clr = 1;
        @(posedge clk); #1 trip_clr = 0;
    endtask

    initial begin
        set_all(0, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R9 reset state
        chk(fast_trip == 0 && secure_trip == 0, "R9 trips after reset", {fast_trip, secure_trip}, 0);
        chk(ext_flag == 0 && brk_trip == 0, "R9 flags after reset", {ext_flag, brk_trip}, 0);

        // R1: pickup alone, slope alone
        set_all(50, 0);   sample(10);
        chk(fast_trip == 0, "R1 below pickup", fast_trip, 0);
        set_all(600, 2000); sample(10);
        chk(fast_trip == 0, "R1 below slope", fast_trip, 0);
        chk(ext_flag == 0, "R5 no flag when op above pickup", ext_flag, 0);

        // R2: broken run
        set_all(1000, 1000); sample(7);
        set_all(0, 0); sample(1);
        set_all(1000, 1000); sample(7);
        chk(fast_trip == 0, "R2 broken run no count", fast_trip, 0);
        sample(1);
        chk(fast_trip == 9'h1FF, "R3 fast trip on first count", fast_trip, 9'h1FF);
        chk(secure_trip == 0, "R4 single count no secure", secure_trip, 0);
        sample(8);
        chk(secure_trip == 9'h1FF, "R4 counts 8 apart secure", secure_trip, 9'h1FF);
        set_all(0, 0);
        sample(2);
        chk(fast_trip == 9'h1FF, "R8 trip latched", fast_trip, 9'h1FF);
        clear_trips();
        chk(fast_trip == 0 && secure_trip == 0, "R8 clear", {fast_trip, secure_trip}, 0);

        // R5 / R6: through-fault blocks fast path
        set_all(0, 2000); sample(7);
        chk(ext_flag == 0, "R5 flag not yet at 7", ext_flag, 0);
        sample(1);
        chk(ext_flag == 9'h1FF, "R5 flag at 8", ext_flag, 9'h1FF);
        set_all(1000, 1000); sample(8);
        chk(fast_trip == 0, "R6 fast blocked", fast_trip, 0);
        set_all(0, 0); sample(10);
        set_all(1000, 1000); sample(8);
        chk(secure_trip == 0, "R4 counts 18 apart no secure", secure_trip, 0);
        sample(8);
        chk(secure_trip == 9'h1FF, "R6 secure allowed while blocked", secure_trip, 9'h1FF);
        chk(fast_trip == 0, "R6 fast still blocked", fast_trip, 0);
        set_all(0, 0);
        clear_trips();
        sample(253);
        chk(ext_flag == 9'h1FF, "R5 flag held 287 strobes", ext_flag, 9'h1FF);
        sample(1);
        chk(ext_flag == 0, "R5 flag drops at 288", ext_flag, 0);

        // R10: no strobe no change
        set_all(1000, 1000);
        repeat (40) @(posedge clk);
        #1;
        chk(fast_trip == 0 && secure_trip == 0, "R10 no strobe", {fast_trip, secure_trip}, 0);
        set_all(0, 0);

        // R7: breaker gating
        op_v[0] = 1000; res_v[0] = 1000; op_v[6] = 1000; res_v[6] = 1000;
        sel_a = 6'b000011; sel_b = 6'b000100; brk_closed = 6'b000101;
        sample(8);
        chk(brk_trip == 6'b000001, "R7 zone A with check", brk_trip, 6'b000001);
        brk_closed = 6'b111111; @(posedge clk); #1;
        chk(brk_trip == 6'b000011, "R7 breaker status", brk_trip, 6'b000011);
        set_all(0, 0);
        clear_trips();
        op_v[3] = 1000; res_v[3] = 1000;
        sample(8);
        chk(brk_trip == 6'b000000, "R7 no check zone", brk_trip, 0);
        op_v[8] = 1000; res_v[8] = 1000;
        sample(8);
        chk(brk_trip == 6'b000100, "R7 zone B with check", brk_trip, 6'b000100);
        set_all(0, 0);
        clear_trips();
        chk(brk_trip == 0, "R8 clear drops breaker trip", brk_trip, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule